// File: doc/BRIEF.md
# Serial Bus Master Transfer Engine

This block drives one synchronous serial transfer as bus master each time it sees a start pulse. The caller gives a transmit symbol count and a receive symbol count, which are independent of each other. It also gives the symbol width, the clock mode, the bit order, a fill symbol and a choice between full-duplex and half-duplex operation. All of these are captured on the start pulse. A programmable divider sets the length of each serial-clock phase in system-clock cycles.

Outgoing symbols are pulled from a ready/valid stream. Incoming symbols are pushed out on a valid-only stream. When the transfer ends, a one-cycle done pulse carries the number of symbols that were clocked on the bus.

In full-duplex mode, each symbol shifts out on the data output while the input is shifted in at the same time. In half-duplex mode the engine first writes all transmit symbols with its output enable high. It then releases the shared wire and reads all receive symbols from it. The board ties that wire to `sdi` and to the tri-state output formed by `sdo`/`sdo_oe`.

Top module: `spi_xfer_engine`

## Requirements
- R1: `spi_mode` bit 1 is the clock idle level and bit 0 selects the phase. With phase 0, `sdi` is sampled on the edge leaving idle and `sdo` changes only on the edge returning to idle. With phase 1, `sdo` changes on the edge leaving idle and `sdi` is sampled on the edge returning to idle. Between symbols and after the transfer, `sclk` rests at the idle level.
- R2: With `lsb_first`=1, bit 0 of each symbol goes first on the wire and the first received bit becomes bit 0. With `lsb_first`=0, bit w-1 goes first.
- R3: `sym_bits` sets the width w (1 to MAX_W; 0 or larger values mean MAX_W). Every symbol takes exactly 2·w clock edges. Received words are right-aligned, with the bits above w equal to zero.
- R4: In full duplex the transfer clocks max(tx_len, rx_len) symbols. Symbols at index tx_len or higher carry `fill_sym`. Only the first rx_len received symbols are delivered.
- R5: With `tx_absent`=1, every written symbol is `fill_sym` and `tx_ready` never rises.
- R6: With `rx_discard`=1, `rx_valid` never rises during the transfer.
- R7: In half duplex the transfer clocks tx_len+rx_len symbols. The first tx_len symbols are written with `sdo_oe`=1 and deliver nothing. The remaining rx_len symbols are read with `sdo_oe`=0 and `tx_ready` low.
- R8: `done` is a one-cycle pulse and `done_count` equals the number of symbols clocked. With both lengths zero, `done` is high in the second cycle after the start edge, with a count of 0.
- R9: During a symbol, each high and each low phase of `sclk` lasts exactly `clk_div`+1 system cycles, using the divider value captured at start.
- R10: All configuration is captured at start. A start pulse while `busy` is high has no effect on the running transfer and produces no extra `done`.
- R11: When a stream symbol is due and `tx_valid` is low, `tx_ready` stays high and `sclk` holds at its idle level until the symbol is accepted.
- R12: After reset, `busy`, `done`, `rx_valid`, `tx_ready`, `sdo_oe` and `sclk` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| tx_len | input | LEN_W | Number of symbols to write |
| rx_len | input | LEN_W | Number of symbols to read |
| tx_absent | input | 1 | No transmit data; send fill symbol throughout |
| rx_discard | input | 1 | Drop all received symbols |
| half_duplex | input | 1 | Write phase then read phase on one wire |
| sym_bits | input | WB | Symbol width in bits |
| spi_mode | input | 2 | {idle level, phase} |
| lsb_first | input | 1 | Bit order select |
| fill_sym | input | MAX_W | Symbol sent when no stream data applies |
| clk_div | input | DIV_W | Serial clock phase length minus one, in system cycles |
| tx_data | input | MAX_W | Transmit stream symbol |
| tx_valid | input | 1 | Transmit stream valid |
| tx_ready | output | 1 | Transmit stream ready |
| rx_data | output | MAX_W | Received symbol |
| rx_valid | output | 1 | Received symbol valid (one cycle) |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |
| sdi | input | 1 | Serial data in (shared wire in half duplex) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished (one cycle) |
| done_count | output | LEN_W+1 | Symbols clocked in the finished transfer |

## Verification
Each `sclk` edge, and with it every `sdo` bit and `sdo_oe` value, is registered on the rising clock edge in which the divider expires. The bench therefore detects edges on the following falling edge, and takes each master bit and each enable value in that same half cycle. It also drives the next slave bit there, so the slave value is settled at least one full cycle before the next sampling edge.

`rx_valid` appears one cycle after the last edge of a symbol, and `done` appears two cycles after the last edge of the transfer. The bench collects both whenever they occur and compares only after `done`, waiting a few more cycles so that stray pulses are also counted. The zero-length case is the one case sampled at fixed cycles: low one cycle after start is taken, high the next cycle, low again after that.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LOAD  = 3'd1,
      ST_SHIFT = 3'd2,
      ST_WRAP  = 3'd3,
      ST_FIN   = 3'd4
   } xfer_state_t;

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart)
         cnt <= '0;
      else if (en)
         cnt <= (cnt == div) ? '0 : cnt + 1'b1;
   end

   assign tick = en && !restart && (cnt == div);

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (div != '0)) |=> !tick); // R9

endmodule

// File: rtl/spi_sym_shifter.sv
module spi_sym_shifter #(
   parameter int MAX_W = 16,
   localparam int WB   = $clog2(MAX_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [MAX_W-1:0] load_val,
   input  logic             lsb_first,
   input  logic [WB-1:0]    width,
   input  logic             shift_en,
   input  logic             sample_en,
   input  logic             sdi,
   output logic             sout,
   output logic [MAX_W-1:0] rx_word
);

   logic [MAX_W-1:0] tx_sr, rx_sr, rev_in, rev_rx, mask;
   logic [WB:0]      pad;

   // bit-reversal networks for LSB-first order
   for (genvar i = 0; i < MAX_W; i++) begin : g_rev
      assign rev_in[i] = load_val[MAX_W-1-i];
      assign rev_rx[i] = rx_sr[MAX_W-1-i];
   end

   assign pad  = (WB+1)'(MAX_W) - {1'b0, width};
   assign mask = ~({MAX_W{1'b1}} << width);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr <= '0;
         rx_sr <= '0;
      end else begin
         if (load)
            tx_sr <= lsb_first ? rev_in : (load_val << pad);
         else if (shift_en)
            tx_sr <= {tx_sr[MAX_W-2:0], 1'b0};
         if (sample_en)
            rx_sr <= {rx_sr[MAX_W-2:0], sdi};
      end
   end

   assign sout    = tx_sr[MAX_W-1];
   assign rx_word = lsb_first ? (rev_rx >> pad) : (rx_sr & mask);

   AST_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (!shift_en && !sample_en)); // R3

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
   import spi_xfer_pkg::*;
#(
   parameter int MAX_W = 16,
   parameter int LEN_W = 5,
   parameter int DIV_W = 8,
   localparam int WB    = $clog2(MAX_W + 1),
   localparam int CNT_W = LEN_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] tx_len,
   input  logic [LEN_W-1:0] rx_len,
   input  logic             tx_absent,
   input  logic             rx_discard,
   input  logic             half_duplex,
   input  logic [WB-1:0]    sym_bits,
   input  logic [1:0]       spi_mode,
   input  logic             lsb_first,
   input  logic [MAX_W-1:0] fill_sym,
   input  logic [DIV_W-1:0] clk_div,
   input  logic [MAX_W-1:0] tx_data,
   input  logic             tx_valid,
   output logic             tx_ready,
   output logic [MAX_W-1:0] rx_data,
   output logic             rx_valid,
   output logic             sclk,
   output logic             sdo,
   output logic             sdo_oe,
   input  logic             sdi,
   output logic             busy,
   output logic             done,
   output logic [CNT_W-1:0] done_count
);

   localparam int EW = WB + 1;
   localparam logic [WB-1:0] WMAX = WB'(MAX_W);

   if (MAX_W < 8 || MAX_W > 64) begin : g_bad_width
      $error("spi_xfer_engine: MAX_W must lie in 8..64");
   end
   if (LEN_W < 1 || DIV_W < 1) begin : g_bad_len
      $error("spi_xfer_engine: LEN_W and DIV_W must be positive");
   end

   xfer_state_t      state;
   logic [LEN_W-1:0] txl, rxl;
   logic             absent_l, discard_l, hd_l, cpol_l, cpha_l, lsb_l;
   logic [WB-1:0]    w_l;
   logic [MAX_W-1:0] fill_l;
   logic [DIV_W-1:0] div_l;
   logic [CNT_W-1:0] total_l, k;
   logic [EW-1:0]    edge_n;
   logic             sclk_q, rxv_q, done_q;
   logic [MAX_W-1:0] rxd_q;
   logic [CNT_W-1:0] cnt_q;

   logic [CNT_W-1:0] total_in;
   logic [WB-1:0]    w_in;
   logic             in_write, need_stream, load_go, keep_rx;
   logic             tick, leading, last_edge, shift_en, sample_en;
   logic [EW-1:0]    edge_last;
   logic             sout;
   logic [MAX_W-1:0] rx_word;

   assign total_in = half_duplex ? ({1'b0, tx_len} + {1'b0, rx_len})
                   : ((tx_len > rx_len) ? {1'b0, tx_len} : {1'b0, rx_len});
   assign w_in     = (sym_bits == '0 || sym_bits > WMAX) ? WMAX : sym_bits;

   assign in_write    = (k < {1'b0, txl});
   assign need_stream = !absent_l && in_write;
   assign load_go     = (state == ST_LOAD) && (!need_stream || tx_valid);
   assign keep_rx     = !discard_l && (hd_l ? !in_write : (k < {1'b0, rxl}));

   assign edge_last = {w_l, 1'b0} - EW'(1);
   assign leading   = !edge_n[0];
   assign last_edge = (edge_n == edge_last);
   assign shift_en  = tick && (cpha_l ? (leading && edge_n != '0) : (!leading && !last_edge));
   assign sample_en = tick && (cpha_l ? !leading : leading);

   spi_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (state == ST_SHIFT),
      .restart (state != ST_SHIFT),
      .div     (div_l),
      .tick    (tick)
   );

   spi_sym_shifter #(.MAX_W(MAX_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_go),
      .load_val  (need_stream ? tx_data : fill_l),
      .lsb_first (lsb_l),
      .width     (w_l),
      .shift_en  (shift_en),
      .sample_en (sample_en),
      .sdi       (sdi),
      .sout      (sout),
      .rx_word   (rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         txl       <= '0;
         rxl       <= '0;
         absent_l  <= 1'b0;
         discard_l <= 1'b0;
         hd_l      <= 1'b0;
         cpol_l    <= 1'b0;
         cpha_l    <= 1'b0;
         lsb_l     <= 1'b0;
         w_l       <= WMAX;
         fill_l    <= '0;
         div_l     <= '0;
         total_l   <= '0;
         k         <= '0;
         edge_n    <= '0;
         sclk_q    <= 1'b0;
         rxv_q     <= 1'b0;
         rxd_q     <= '0;
         done_q    <= 1'b0;
         cnt_q     <= '0;
      end else begin
         rxv_q  <= 1'b0;
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               sclk_q <= spi_mode[1];
               if (start) begin
                  txl       <= tx_len;
                  rxl       <= rx_len;
                  absent_l  <= tx_absent;
                  discard_l <= rx_discard;
                  hd_l      <= half_duplex;
                  cpol_l    <= spi_mode[1];
                  cpha_l    <= spi_mode[0];
                  lsb_l     <= lsb_first;
                  w_l       <= w_in;
                  fill_l    <= fill_sym;
                  div_l     <= clk_div;
                  total_l   <= total_in;
                  k         <= '0;
                  state     <= (total_in == '0) ? ST_FIN : ST_LOAD;
               end
            end
            ST_LOAD: begin
               if (load_go) begin
                  edge_n <= '0;
                  state  <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  sclk_q <= ~sclk_q;
                  edge_n <= edge_n + 1'b1;
                  if (last_edge)
                     state <= ST_WRAP;
               end
            end
            ST_WRAP: begin
               if (keep_rx) begin
                  rxv_q <= 1'b1;
                  rxd_q <= rx_word;
               end
               k     <= k + 1'b1;
               state <= (k + 1'b1 == total_l) ? ST_FIN : ST_LOAD;
            end
            ST_FIN: begin
               done_q <= 1'b1;
               cnt_q  <= k;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state != ST_IDLE);
   assign tx_ready   = (state == ST_LOAD) && need_stream;
   assign sclk       = sclk_q;
   assign sdo        = sout;
   assign sdo_oe     = busy && (!hd_l || in_write);
   assign rx_valid   = rxv_q;
   assign rx_data    = rxd_q;
   assign done       = done_q;
   assign done_count = cnt_q;

   // cycles since the last divider expiry, kept apart from the divider itself
   logic [DIV_W-1:0] ph_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ph_cnt <= '0;
      else if (tick)
         ph_cnt <= '0;
      else if (ph_cnt != '1)
         ph_cnt <= ph_cnt + 1'b1;
   end

   AST_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> (ph_cnt >= div_l)); // R9
   AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOAD) |-> (sclk == cpol_l)); // R1
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(total_l) && $stable(w_l) && $stable(div_l))); // R10
   AST_NO_RX_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !discard_l); // R6
   AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && absent_l) |-> !tx_ready); // R5
   AST_HD_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && hd_l && !sdo_oe) |-> !tx_ready); // R7
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && !tx_valid) |=> (tx_ready && $stable(sclk))); // R11

endmodule

// File: tb/sim_spi_xfer_engine.sv
module sim_spi_xfer_engine;

   localparam int CLK_P = 10;
   localparam int MAX_W = 16;
   localparam int LEN_W = 5;
   localparam int DIV_W = 8;

   typedef struct packed {
      logic [3:0]  txl;
      logic [3:0]  rxl;
      logic [4:0]  bits;
      logic [1:0]  mode;
      logic        lsb;
      logic        hd;
      logic        absent;
      logic        discard;
      logic [3:0]  div;
      logic [15:0] fill;
   } vec_t;

   localparam vec_t VEC [0:7] = '{
      '{4'd3, 4'd3, 5'd8,  2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 16'h00FF},
      '{4'd2, 4'd5, 5'd8,  2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 16'h005A},
      '{4'd4, 4'd2, 5'd12, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0ABC},
      '{4'd3, 4'd4, 5'd5,  2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1, 16'h0013},
      '{4'd4, 4'd3, 5'd16, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3, 16'hBEEF},
      '{4'd2, 4'd3, 5'd8,  2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1, 16'h0000},
      '{4'd3, 4'd2, 5'd7,  2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'd2, 16'h0000},
      '{4'd0, 4'd3, 5'd8,  2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 16'h0000}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [LEN_W-1:0] tx_len = '0, rx_len = '0;
   logic             tx_absent = 1'b0, rx_discard = 1'b0, half_duplex = 1'b0;
   logic [4:0]       sym_bits = 5'd8;
   logic [1:0]       spi_mode = 2'd0;
   logic             lsb_first = 1'b0;
   logic [MAX_W-1:0] fill_sym = '0;
   logic [DIV_W-1:0] clk_div = '0;
   logic [MAX_W-1:0] tx_data = '0;
   logic             tx_valid = 1'b0;
   logic             tx_ready;
   logic [MAX_W-1:0] rx_data;
   logic             rx_valid, sclk, sdo, sdo_oe, busy, done;
   logic             sdi = 1'b0;
   logic [LEN_W:0]   done_count;

   spi_xfer_engine #(.MAX_W(MAX_W), .LEN_W(LEN_W), .DIV_W(DIV_W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_len(tx_len), .rx_len(rx_len),
      .tx_absent(tx_absent), .rx_discard(rx_discard), .half_duplex(half_duplex),
      .sym_bits(sym_bits), .spi_mode(spi_mode), .lsb_first(lsb_first),
      .fill_sym(fill_sym), .clk_div(clk_div), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk),
      .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi), .busy(busy), .done(done),
      .done_count(done_count)
   );

   always #(CLK_P/2) clk = ~clk;

   int n_chk = 0, n_bad = 0;

   // bench-side model state
   int         cw = 8;
   logic       cl = 1'b0, ccpol = 1'b0, ccpha = 1'b0;
   int         vsel = 0;
   logic [15:0] txsyms [0:15];
   int         ntx = 0, tx_idx = 0;
   logic       hs_pend = 1'b0, tx_en = 1'b0, stall = 1'b0;
   logic       mbits [0:511];
   logic       oeb   [0:511];
   logic [15:0] rxq  [0:31];
   int         nb = 0, nrx = 0, ndone = 0, got_cnt = 0, sl_pos = 0;
   int         cyc_since = 1000, minph = 1000;
   logic       prev_sclk = 1'b0;

   function automatic logic [15:0] slave_sym(int s);
      return 16'hB7E1 + 16'(s) * 16'h0F31 + 16'(vsel) * 16'h0101;
   endfunction

   function automatic logic sbit(int pos);
      logic [15:0] val;
      int s, b;
      s   = pos / cw;
      b   = pos % cw;
      val = slave_sym(s);
      return cl ? val[b] : val[cw-1-b];
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // slave model and stream driver, all on the falling edge
   initial begin
      logic lead;
      int   ph;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (sclk !== prev_sclk) begin
               ph = cyc_since + 1;
               if (ph < minph) minph = ph;
               cyc_since = 0;
               lead = (prev_sclk == ccpol);
               if (ccpha ? !lead : lead) begin
                  if (nb < 512) begin
                     mbits[nb] = sdo;
                     oeb[nb]   = sdo_oe;
                  end
                  nb++;
                  sl_pos++;
                  sdi = sbit(sl_pos);
               end
               prev_sclk = sclk;
            end else begin
               cyc_since++;
            end
            if (rx_valid) begin
               if (nrx < 32) rxq[nrx] = rx_data;
               nrx++;
            end
            if (done) begin
               ndone++;
               got_cnt = int'(done_count);
            end
            if (hs_pend) begin
               tx_idx++;
               hs_pend = 1'b0;
            end
            tx_valid = tx_en && !stall && (tx_idx < ntx);
            tx_data  = (tx_idx < ntx) ? txsyms[tx_idx] : '0;
            hs_pend  = tx_ready && tx_valid;
         end
      end
   end

   task automatic run_vec(input int vi, input vec_t v, input bit do_stall, input bit do_restart);
      int txl, rxl, w, total, mism, oemis, exp_rx, rxbad, guard;
      logic [15:0] val, mask, ev;
      txl = int'(v.txl);
      rxl = int'(v.rxl);
      w   = int'(v.bits);
      total = v.hd ? txl + rxl : ((txl > rxl) ? txl : rxl);
      mask = (w >= 16) ? 16'hFFFF : ((16'h1 << w) - 16'h1);

      @(negedge clk);
      vsel = vi; cw = w; cl = v.lsb; ccpol = v.mode[1]; ccpha = v.mode[0];
      for (int k = 0; k < 16; k++)
         txsyms[k] = 16'h3C5A ^ (16'(k) * 16'h1111) ^ (16'(vi) * 16'h0707);
      tx_len = LEN_W'(txl); rx_len = LEN_W'(rxl);
      tx_absent = v.absent; rx_discard = v.discard; half_duplex = v.hd;
      sym_bits = v.bits; spi_mode = v.mode; lsb_first = v.lsb;
      fill_sym = v.fill; clk_div = DIV_W'(v.div);
      stall = do_stall;
      repeat (2) @(negedge clk);
      nb = 0; nrx = 0; ndone = 0; got_cnt = -1; sl_pos = 0; minph = 1000;
      cyc_since = 1000; prev_sclk = sclk; sdi = sbit(0);
      ntx = txl; tx_idx = 0; hs_pend = 1'b0; tx_en = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (do_stall) begin
         repeat (20) @(negedge clk);
         chk(busy && sclk == v.mode[1] && nb == 0 && tx_ready, "R11 clock held while stream stalls", nb, 0);
         stall = 1'b0;
      end
      if (do_restart) begin
         repeat (10) @(negedge clk);
         tx_len = LEN_W'(9); half_duplex = ~v.hd;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      guard = 0;
      while (ndone == 0 && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      repeat (4) @(negedge clk);
      tx_en = 1'b0;

      chk(got_cnt == total, "R4 R7 R8 done_count", got_cnt, total);
      chk(ndone == 1, "R8 R10 done pulses", ndone, 1);
      chk(nb == total * w, "R3 sampling edges", nb, total * w);

      mism = 0; oemis = 0;
      for (int p = 0; p < nb && p < 512; p++) begin
         int s, b;
         s = p / w;
         b = p % w;
         if (oeb[p] !== ((v.hd && s >= txl) ? 1'b0 : 1'b1)) oemis++;
         if (!(v.hd && s >= txl)) begin
            val = (s < txl && !v.absent) ? txsyms[s] : v.fill;
            if (mbits[p] !== (v.lsb ? val[b] : val[w-1-b])) mism++;
         end
      end
      chk(mism == 0, "R1 R2 R4 R5 master bits", mism, 0);
      chk(oemis == 0, "R7 output enable by phase", oemis, 0);

      exp_rx = 0; rxbad = 0;
      for (int k = 0; k < total; k++) begin
         if (!v.discard && (v.hd ? (k >= txl) : (k < rxl))) begin
            ev = slave_sym(k) & mask;
            if (exp_rx < nrx && exp_rx < 32 && rxq[exp_rx] !== ev) rxbad++;
            exp_rx++;
         end
      end
      chk(nrx == exp_rx, "R4 R6 R7 received count", nrx, exp_rx);
      chk(rxbad == 0, "R2 R3 received values", rxbad, 0);
      chk(minph == int'(v.div) + 1, "R9 phase length", minph, int'(v.div) + 1);
      chk(sclk == v.mode[1], "R1 idle level after transfer", int'(sclk), int'(v.mode[1]));
      chk(tx_idx == (v.absent ? 0 : txl), "R5 R11 stream symbols taken", tx_idx, v.absent ? 0 : txl);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      repeat (145000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(!busy && !done && !rx_valid && !tx_ready && !sdo_oe && !sclk,
          "R12 reset state", int'({busy, done, rx_valid, tx_ready, sdo_oe, sclk}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < 8; i++)
         run_vec(i, VEC[i], 1'b0, 1'b0);

      // R11 stalled stream, R10 start while busy
      run_vec(8, VEC[0], 1'b1, 1'b0);
      run_vec(9, VEC[2], 1'b0, 1'b1);

      // R8 zero-length transfer timing
      @(negedge clk);
      tx_len = '0; rx_len = '0; half_duplex = 1'b0; ndone = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!done, "R8 zero length, first cycle", int'(done), 0);
      @(negedge clk);
      chk(done && done_count == '0, "R8 zero length done", int'(done_count), 0);
      @(negedge clk);
      chk(!done && !busy, "R8 zero length single pulse", int'(done), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule